// File: doc/BRIEF.md
# Four-Mode SPI Master with Held Chip Select

This block is a synchronous SPI master. It moves one byte at a time in full duplex: eight bits leave on MOSI, most significant first, and eight bits are captured from MISO in the same transfer. The user side starts a byte with a one-cycle start pulse. With that pulse it gives the outgoing byte, the index of the target select, a divider value, the clock polarity and clock phase, and a flag that keeps the select asserted once the byte ends.

The serial clock is derived from the system clock. Each SCLK half-period lasts a whole number of system clocks, set by the divider. When a transaction begins with all selects high, the block first parks SCLK at the idle level of the chosen mode. Only then does it pull exactly one active-low select line low. If the hold flag was set for a byte, the select and the mode stay in force for the next byte, so several bytes form one transaction. The select is released only after a byte whose hold flag is clear.

A done strobe marks the cycle in which the received byte is valid. A new start is accepted in that same cycle, so bytes can run back to back.

Top module: `spiMaster`

## Requirements
- R1: While reset is held and just after it, every select line is high, SCLK is low, and busyOut and doneOut are low.
- R2: At a transaction start with all selects high, SCLK first moves to its idle level, which is low for cpolIn=0 and high for cpolIn=1. The select goes low with SCLK already at that level, one half-period after the start is accepted. SCLK stays still while the block is idle with all selects high.
- R3: The slave samples on the first SCLK edge of each bit when cphaIn=0, and on the second edge when cphaIn=1. Mode number = 2*cpolIn + cphaIn, so modes 0 and 3 sample on rising edges and modes 1 and 2 sample on falling edges. With cphaIn=0 the first MOSI bit is valid before the first edge.
- R4: Each byte is full duplex and MSB first. The slave receives txByte bit 7 down to bit 0, and rxByte holds the eight MISO bits with the first one in bit 7.
- R5: Every SCLK half-period lasts divIn+1 system clocks. The divider value is taken at start.
- R6: At most one select is low at any time. Target index k drives selN[k] low.
- R7: With holdSel set, the select stays low after the byte. After a byte with holdSel clear, the select returns high one half-period after the last SCLK edge, and SCLK is at its idle level.
- R8: A start pulse that arrives while busyOut is high is ignored. The running byte, the select and the byte count are unaffected.
- R9: doneOut is high for exactly one clock, with the valid rxByte and with busyOut already low. A start in that cycle is accepted, and busyOut is high in the next cycle.
- R10: While a select is held, the target index and the cpolIn/cphaIn given with the next start are ignored. The held select and its mode stay in use.
- R11: Every byte produces exactly 16 SCLK edges, and SCLK ends at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | One-cycle request to send a byte |
| txByte | input | 8 | Byte to send |
| tgtSel | input | 2 | Index of the select line to drive |
| holdSel | input | 1 | Keep the select low after this byte |
| divIn | input | 8 | Half-period length minus one, in system clocks |
| cpolIn | input | 1 | Clock polarity (idle level) |
| cphaIn | input | 1 | Clock phase (0: sample on first edge) |
| busyOut | output | 1 | Byte in progress |
| doneOut | output | 1 | One-cycle strobe, rxByte valid |
| rxByte | output | 8 | Received byte |
| sclkOut | output | 1 | Serial clock |
| mosiOut | output | 1 | Serial data to the slave |
| misoIn | input | 1 | Serial data from the slave |
| selN | output | 4 | Active-low select lines |

## Verification
The end of one byte and the start of the next can fall in the same cycle. The done strobe opens an acceptance window while the previous select may still be held. The bench drives startIn in the very cycle it observes doneOut, both inside held chains and after released bytes. It then judges the next byte by the slave-side bit stream, the edge count, the select line and the timing between edges. A stray start in the middle of every byte tests whether it is ignored against the same slave-side record.

// File: rtl/spi_mst_pkg.sv
package spi_mst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_TRAIL,
    ST_DONE
  } mstState_t;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic latchCfg;   // fresh transaction: take polarity and target
    logic loadByte;   // take the outgoing byte
    logic assertSel;  // drive the chosen select low
    logic releaseSel; // drive all selects high
    logic toggleClk;  // flip SCLK
    logic sampleBit;  // capture MISO
    logic shiftBit;   // present the next MOSI bit
  } mstStrobe_t;

endpackage

// File: rtl/spi_mst_ctrl.sv
module spi_mst_ctrl
  import spi_mst_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic             holdSel,
  input  logic             cphaIn,
  input  logic [DIV_W-1:0] divIn,
  output mstStrobe_t       strb,
  output logic             busyOut,
  output logic             doneOut
);
  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES + 1);

  mstState_t         stateQ;
  logic [DIV_W-1:0]  divQ;
  logic [DIV_W-1:0]  cntQ;
  logic [EDGE_W-1:0] edgeQ;
  logic              cphaQ;
  logic              holdQ;
  logic              heldQ;

  logic tick;
  logic canStart;
  logic leading;
  logic sampleNow;
  logic lastEdge;
  logic shiftNow;

  assign tick      = (cntQ == divQ);
  assign canStart  = (stateQ == ST_IDLE) || (stateQ == ST_DONE);
  assign leading   = ~edgeQ[0];
  assign sampleNow = leading ^ cphaQ;
  assign lastEdge  = (edgeQ == EDGE_W'(EDGES - 1));
  // shifts happen on the non-sampling edges from the second to the next-to-last
  assign shiftNow  = ~sampleNow && (edgeQ != '0) && ~lastEdge;

  assign busyOut = (stateQ == ST_SETUP) || (stateQ == ST_XFER) || (stateQ == ST_TRAIL);
  assign doneOut = (stateQ == ST_DONE);

  always_comb begin
    strb = '0;
    unique case (stateQ)
      ST_IDLE, ST_DONE: begin
        strb.loadByte = startIn;
        strb.latchCfg = startIn && ~heldQ;
      end
      ST_SETUP: strb.assertSel = tick;
      ST_XFER: begin
        strb.toggleClk = tick;
        strb.sampleBit = tick && sampleNow;
        strb.shiftBit  = tick && shiftNow;
      end
      ST_TRAIL: strb.releaseSel = tick;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      divQ   <= '0;
      cntQ   <= '0;
      edgeQ  <= '0;
      cphaQ  <= 1'b0;
      holdQ  <= 1'b0;
      heldQ  <= 1'b0;
    end else begin
      if (busyOut) cntQ <= tick ? '0 : cntQ + 1'b1;
      unique case (stateQ)
        ST_IDLE, ST_DONE: begin
          stateQ <= ST_IDLE;
          if (startIn) begin
            divQ  <= divIn;
            holdQ <= holdSel;
            cntQ  <= '0;
            edgeQ <= '0;
            if (heldQ) begin
              stateQ <= ST_XFER;
            end else begin
              stateQ <= ST_SETUP;
              cphaQ  <= cphaIn;
            end
          end
        end
        ST_SETUP: if (tick) stateQ <= ST_XFER;
        ST_XFER: begin
          if (tick) begin
            edgeQ <= edgeQ + 1'b1;
            if (lastEdge) begin
              if (holdQ) begin
                heldQ  <= 1'b1;
                stateQ <= ST_DONE;
              end else begin
                stateQ <= ST_TRAIL;
              end
            end
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            heldQ  <= 1'b0;
            stateQ <= ST_DONE;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_mst_dp.sv
module spi_mst_dp
  import spi_mst_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_SEL = 4,
  parameter int SEL_W   = $clog2(NUM_SEL)
) (
  input  logic               clk,
  input  logic               rstN,
  input  mstStrobe_t         strb,
  input  logic [DATA_W-1:0]  txByte,
  input  logic [SEL_W-1:0]   tgtSel,
  input  logic               cpolIn,
  input  logic               misoIn,
  output logic               sclkOut,
  output logic               mosiOut,
  output logic [NUM_SEL-1:0] selN,
  output logic [DATA_W-1:0]  rxByte
);
  logic [DATA_W-1:0]  txQ;
  logic [DATA_W-1:0]  rxQ;
  logic [SEL_W-1:0]   selQ;
  logic [NUM_SEL-1:0] selNQ;
  logic [NUM_SEL-1:0] selDecN;
  logic               sclkQ;

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_selDec
    assign selDecN[i] = (selQ != SEL_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txQ   <= '0;
      rxQ   <= '0;
      selQ  <= '0;
      selNQ <= '1;
      sclkQ <= 1'b0;
    end else begin
      if (strb.latchCfg) begin
        sclkQ <= cpolIn;
        selQ  <= tgtSel;
      end
      if (strb.toggleClk) sclkQ <= ~sclkQ;
      if (strb.loadByte) txQ <= txByte;
      else if (strb.shiftBit) txQ <= {txQ[DATA_W-2:0], 1'b0};
      if (strb.sampleBit) rxQ <= {rxQ[DATA_W-2:0], misoIn};
      if (strb.assertSel) selNQ <= selDecN;
      else if (strb.releaseSel) selNQ <= '1;
    end
  end

  assign sclkOut = sclkQ;
  assign mosiOut = txQ[DATA_W-1];
  assign selN    = selNQ;
  assign rxByte  = rxQ;

endmodule

// File: rtl/spiMaster.sv
module spiMaster
  import spi_mst_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_SEL = 4,
  parameter int DIV_W   = 8,
  localparam int SEL_W  = $clog2(NUM_SEL)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startIn,
  input  logic [DATA_W-1:0]  txByte,
  input  logic [SEL_W-1:0]   tgtSel,
  input  logic               holdSel,
  input  logic [DIV_W-1:0]   divIn,
  input  logic               cpolIn,
  input  logic               cphaIn,
  output logic               busyOut,
  output logic               doneOut,
  output logic [DATA_W-1:0]  rxByte,
  output logic               sclkOut,
  output logic               mosiOut,
  input  logic               misoIn,
  output logic [NUM_SEL-1:0] selN
);
  mstStrobe_t strb;

  spi_mst_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .holdSel (holdSel),
    .cphaIn  (cphaIn),
    .divIn   (divIn),
    .strb    (strb),
    .busyOut (busyOut),
    .doneOut (doneOut)
  );

  spi_mst_dp #(.DATA_W(DATA_W), .NUM_SEL(NUM_SEL), .SEL_W(SEL_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .txByte  (txByte),
    .tgtSel  (tgtSel),
    .cpolIn  (cpolIn),
    .misoIn  (misoIn),
    .sclkOut (sclkOut),
    .mosiOut (mosiOut),
    .selN    (selN),
    .rxByte  (rxByte)
  );

endmodule

// File: rtl/spi_mst_chk.sv
module spi_mst_chk #(
  parameter int NUM_SEL = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               startIn,
  input logic               busyOut,
  input logic               doneOut,
  input logic               sclkOut,
  input logic [NUM_SEL-1:0] selN
);
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~selN)); // R6

  AST_SCLK_SETTLED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(&selN) |-> $stable(sclkOut)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (&selN && !busyOut && $past(!busyOut)) |-> $stable(sclkOut)); // R2

  AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(&selN) |-> $stable(sclkOut)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut); // R9

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !busyOut) |=> busyOut); // R9

endmodule

bind spiMaster spi_mst_chk #(.NUM_SEL(NUM_SEL)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .startIn (startIn),
  .busyOut (busyOut),
  .doneOut (doneOut),
  .sclkOut (sclkOut),
  .selN    (selN)
);

// File: tb/spiMaster_test.sv
module spiMaster_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startIn = 1'b0;
  logic [7:0] txByte = '0;
  logic [1:0] tgtSel = '0;
  logic       holdSel = 1'b0;
  logic [7:0] divIn = '0;
  logic       cpolIn = 1'b0;
  logic       cphaIn = 1'b0;
  logic       busyOut, doneOut, sclkOut, mosiOut, misoIn;
  logic [7:0] rxByte;
  logic [3:0] selN;

  spiMaster uut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .txByte(txByte), .tgtSel(tgtSel),
    .holdSel(holdSel), .divIn(divIn), .cpolIn(cpolIn), .cphaIn(cphaIn),
    .busyOut(busyOut), .doneOut(doneOut), .rxByte(rxByte), .sclkOut(sclkOut),
    .mosiOut(mosiOut), .misoIn(misoIn), .selN(selN)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int testsRun = 0;
  int testsFailed = 0;

  // bench-side view of the transaction
  logic       expCpol = 1'b0, expCpha = 1'b0;
  logic [1:0] expIdx = '0;
  int         expH = 1;
  logic       benchHeld = 1'b0;
  logic       inByte = 1'b0;

  // slave model state
  logic [7:0] slvShift = '0, slvRx = '0;
  int         drvCnt = 0, edgeCnt = 0, gapErr = 0;
  longint     lastEdgeT = 0, selFallT = 0, releaseT = 0;
  logic       sclkAtFall = 1'b0, sawFall = 1'b0, sawRelease = 1'b0;
  logic [3:0] selAtFall = '0;
  logic       prevAllHigh = 1'b0;

  always_comb misoIn = slvShift[7];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  // slave: reacts to each SCLK edge while a select is low
  always @(sclkOut) begin
    if (rstN && inByte && selN != 4'hf) begin
      logic lead;
      lead = (sclkOut != expCpol);
      if (edgeCnt == 0) begin
        if (sawFall && ($time - selFallT) != longint'(expH * CLK_PERIOD)) gapErr++;
      end else if (($time - lastEdgeT) != longint'(expH * CLK_PERIOD)) gapErr++;
      lastEdgeT = $time;
      edgeCnt++;
      if (lead == !expCpha) slvRx = {slvRx[6:0], mosiOut};
      else begin
        if (!(expCpha && drvCnt == 0)) slvShift = slvShift << 1;
        drvCnt++;
      end
    end
  end

  always @(selN) begin
    if (selN != 4'hf && prevAllHigh) begin
      sawFall = 1'b1; selFallT = $time; sclkAtFall = sclkOut; selAtFall = selN;
    end
    if (selN == 4'hf && !prevAllHigh && inByte) begin
      sawRelease = 1'b1; releaseT = $time;
    end
    prevAllHigh = (selN == 4'hf);
  end

  // one byte; called at a negedge, returns at the negedge where doneOut is seen
  task automatic runByte(input logic [7:0] tx, input logic [7:0] resp, input logic [1:0] idx,
                         input logic hold, input logic [7:0] div, input logic cpol,
                         input logic cpha);
    bit fresh;
    int waitCnt;
    fresh = !benchHeld;
    if (fresh) begin expCpol = cpol; expCpha = cpha; expIdx = idx; end
    expH = int'(div) + 1;
    slvShift = resp; slvRx = '0; drvCnt = 0; edgeCnt = 0; gapErr = 0;
    sawFall = 1'b0; sawRelease = 1'b0; inByte = 1'b1;
    txByte = tx; tgtSel = idx; holdSel = hold; divIn = div; cpolIn = cpol; cphaIn = cpha;
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    check(busyOut == 1'b1, "R9 start accepted", busyOut, 1);
    waitCnt = 0;
    while (!doneOut && waitCnt < 5000) begin
      if (waitCnt == 2) begin // R8 stray request while busy
        startIn = 1'b1; txByte = ~tx; tgtSel = idx + 2'd1; cpolIn = ~cpol; divIn = div + 8'd3;
      end else begin
        startIn = 1'b0;
      end
      @(negedge clk);
      waitCnt++;
    end
    startIn = 1'b0;
    inByte = 1'b0;
    check(doneOut == 1'b1, "R9 done reached", doneOut, 1);
    check(busyOut == 1'b0, "R9 busy low at done", busyOut, 0);
    check(slvRx == tx, "R4 R8 slave received byte", slvRx, tx);
    check(rxByte == resp, "R3 R4 master received byte", rxByte, resp);
    check(edgeCnt == 16, "R11 edge count", edgeCnt, 16);
    check(sclkOut == expCpol, "R11 idle level at end", sclkOut, expCpol);
    check(gapErr == 0, "R5 half-period length", gapErr, 0);
    if (fresh) begin
      check(sawFall && sclkAtFall == expCpol, "R2 idle level before select", sclkAtFall, expCpol);
      check(selAtFall == ~(4'b1 << expIdx), "R6 select decode", selAtFall, ~(4'b1 << expIdx));
    end
    if (hold) begin
      check(selN == ~(4'b1 << expIdx), "R7 R10 select held", selN, ~(4'b1 << expIdx));
    end else begin
      check(selN == 4'hf, "R7 select released", selN, 4'hf);
      check(sawRelease && (releaseT - lastEdgeT) == longint'(expH * CLK_PERIOD),
            "R7 release delay", int'(releaseT - lastEdgeT), expH * CLK_PERIOD);
    end
    benchHeld = hold;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    testsRun++; testsFailed++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    check(selN == 4'hf && sclkOut == 1'b0 && !busyOut && !doneOut, "R1 reset state",
          {selN, sclkOut, busyOut, doneOut}, 8'hf0 >> 1);
    rstN = 1'b1;
    @(negedge clk);
    check(selN == 4'hf && sclkOut == 1'b0 && !busyOut && !doneOut, "R1 after reset",
          {selN, sclkOut, busyOut, doneOut}, 8'hf0 >> 1);

    // R3: all four modes, fastest clock
    for (int m = 0; m < 4; m++) begin
      runByte(8'hA5 ^ 8'(m), 8'h3C + 8'(m), 2'(m), 1'b0, 8'd0, m[1], m[0]);
      repeat (2) @(negedge clk);
    end
    // R5: slow divider
    runByte(8'h81, 8'h7E, 2'd3, 1'b0, 8'd5, 1'b1, 1'b0);
    @(negedge clk);
    // R7 R10: held chain; later starts try other index and mode
    runByte(8'h11, 8'hC3, 2'd2, 1'b1, 8'd1, 1'b0, 1'b1);
    runByte(8'h22, 8'h96, 2'd0, 1'b1, 8'd2, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    check(selN == 4'b1011 && !busyOut, "R7 select held between bytes", selN, 4'b1011);
    runByte(8'h33, 8'h5A, 2'd1, 1'b0, 8'd0, 1'b1, 1'b1);
    // R9: back-to-back fresh byte in the done cycle
    runByte(8'hF0, 8'h0F, 2'd1, 1'b0, 8'd2, 1'b1, 1'b1);

    for (int i = 0; i < 24; i++) begin
      logic [7:0] tx, rs, dv;
      logic [1:0] ix;
      logic hd, cp, ch;
      tx = 8'($urandom); rs = 8'($urandom); dv = 8'($urandom % 4);
      ix = 2'($urandom); cp = 1'($urandom); ch = 1'($urandom);
      hd = (i != 23) && ($urandom % 3 == 0);
      runByte(tx, rs, ix, hd, dv, cp, ch);
      repeat ($urandom % 3) @(negedge clk);
    end

    repeat (4) @(negedge clk);
    check(selN == 4'hf && !busyOut && !doneOut, "R8 quiet after last byte", selN, 4'hf);
    finishRun();
  end

endmodule